// File: doc/BRIEF.md
# Raster Line Match Sequencer

This block decides where horizontal marker lines fall on a raster display. It holds eight candidate line addresses: the position of a moving cursor, six stored cursor slots and an internal load-line counter. When a vertical retrace begins, it steps a 3-bit selector through the eight addresses, one per clock. It compares each selected address with the raster line count taken at the start of the retrace.

Each equality produces a one-clock match pulse tagged with the index of the source that matched. The pulse comes with the action that source calls for. Cursor sources (the moving cursor and the stored slots) request that a line be drawn. The load-line source requests a memory-load sequence instead. A stored slot can also be flagged for erasure when an erase request is active and the slot sits on the moving cursor.

The load-line counter advances once for each data-loaded strobe. Its value is exposed so that the rest of the display path can follow it.

Top module: `raster_mark_scan`

## Requirements
- R1: While reset is asserted and in the first cycle after it, eq_pulse, draw_pulse, erase_pulse and load_pulse are 0 and load_line is 0.
- R2: A rising edge of retrace, seen while no scan is running, starts a scan. The scan visits indexes 0 to 7 in ascending order, one per clock. Each address is compared with the line_cnt value sampled on the clock edge that detected the retrace rise. Later changes of line_cnt do not affect that scan.
- R3: Every index whose address equals the captured line produces its own one-clock eq_pulse, with eq_src set to that index (3 bits, 0 = moving cursor, 1..6 = stored slot 1..6, 7 = load line). When several indexes match, their pulses appear in ascending index order. With no match, no pulse appears.
- R4: A match at any index from 0 to 6 asserts draw_pulse in the same cycle as eq_pulse.
- R5: A match at index 7 asserts load_pulse and not draw_pulse, in the same cycle as eq_pulse.
- R6: A stored slot i (index i, bit i-1 of stored_busy) whose busy flag is 0 never produces a match.
- R7: erase_pulse is asserted together with eq_pulse for a stored slot only when erase_req is high and the slot address equals move_addr. It never accompanies index 0 or index 7.
- R8: load_line starts at 0, increases by 1 in each clock in which data_loaded is high, and wraps from 511 to 0 (AW = 9).
- R9: A new retrace rising edge that arrives while a scan is running is ignored. That scan produces exactly one set of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retrace | input | 1 | Vertical retrace level; its rising edge starts a scan |
| data_loaded | input | 1 | One strobe per new data set; advances load_line |
| erase_req | input | 1 | Erase request applied to stored slots during a scan |
| move_addr | input | AW | Moving cursor line address (index 0) |
| stored_addr | input | 6*AW | Stored slot addresses; slot i occupies bits [i*AW-1 -: AW] |
| stored_busy | input | 6 | Occupancy flags; bit i-1 belongs to slot i |
| line_cnt | input | AW | Current raster vertical line number |
| eq_pulse | output | 1 | One-clock match pulse |
| eq_src | output | 3 | Index of the matching source |
| draw_pulse | output | 1 | Draw a cursor line (indexes 0..6) |
| erase_pulse | output | 1 | Erase the matched stored slot |
| load_pulse | output | 1 | Start a memory-load sequence (index 7) |
| load_line | output | AW | Load-line counter value |

## Verification
The bench builds the block with AW = 9. That makes the counter's 511-to-0 wrap reachable in 512 strobes and keeps every address a real display line. With that width, a scan can be given coincident addresses across the moving cursor, several stored slots and the load line, so that index ordering can be checked. It also covers slots that hold matching addresses while their busy flag is clear, and a second retrace rise landing in the middle of a running scan.

// File: rtl/raster_mark_scan.sv
module raster_mark_scan #(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retrace,
  input  logic              data_loaded,
  input  logic              erase_req,
  input  logic [AW-1:0]     move_addr,
  input  logic [6*AW-1:0]   stored_addr,
  input  logic [5:0]        stored_busy,
  input  logic [AW-1:0]     line_cnt,
  output logic              eq_pulse,
  output logic [2:0]        eq_src,
  output logic              draw_pulse,
  output logic              erase_pulse,
  output logic              load_pulse,
  output logic [AW-1:0]     load_line
);
  localparam int NSTORE = 6;
  localparam int NPOS   = NSTORE + 2;
  localparam int SW     = $clog2(NPOS);
  localparam logic [SW-1:0] LAST = SW'(NPOS - 1);

  logic          retrace_q, active;
  logic [SW-1:0] sel;
  logic [AW-1:0] line_cap;
  logic [AW-1:0] sel_addr;
  logic          sel_valid, sel_stored, sel_on_move;

  wire start = retrace & ~retrace_q & ~active;

  always_comb begin
    sel_addr    = move_addr;
    sel_valid   = 1'b1;
    sel_stored  = 1'b0;
    sel_on_move = 1'b0;
    if (sel == LAST) sel_addr = load_line;
    for (int i = 0; i < NSTORE; i++) begin
      if (sel == SW'(i + 1)) begin
        sel_addr    = stored_addr[i*AW +: AW];
        sel_valid   = stored_busy[i];
        sel_stored  = 1'b1;
        sel_on_move = (stored_addr[i*AW +: AW] == move_addr);
      end
    end
  end

  wire hit = active & sel_valid & (sel_addr == line_cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retrace_q   <= 1'b0;
      active      <= 1'b0;
      sel         <= '0;
      line_cap    <= '0;
      eq_pulse    <= 1'b0;
      eq_src      <= '0;
      draw_pulse  <= 1'b0;
      erase_pulse <= 1'b0;
      load_pulse  <= 1'b0;
    end else begin
      retrace_q   <= retrace;
      eq_pulse    <= hit;
      eq_src      <= 3'(sel);
      draw_pulse  <= hit & (sel != LAST);
      load_pulse  <= hit & (sel == LAST);
      erase_pulse <= hit & sel_stored & erase_req & sel_on_move;
      if (start) begin
        active   <= 1'b1;
        sel      <= '0;
        line_cap <= line_cnt;
      end else if (active) begin
        if (sel == LAST) active <= 1'b0;
        else             sel    <= sel + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           load_line <= '0;
    else if (data_loaded) load_line <= load_line + 1'b1;
  end

  assert_pulse_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eq_pulse |-> $past(active));
  assert_load_only_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> (eq_pulse && eq_src == 3'd7 && !draw_pulse));
  assert_draw_cursor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    draw_pulse |-> (eq_pulse && eq_src != 3'd7));
  assert_skip_idle_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_pulse && eq_src != 3'd0 && eq_src != 3'd7) |->
      ((($past(stored_busy) >> (eq_src - 3'd1)) & 6'd1) != 6'd0));
  assert_erase_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> (eq_pulse && eq_src != 3'd0 && eq_src != 3'd7 && $past(erase_req)));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(data_loaded)) |-> (load_line == AW'($past(load_line) + 1'b1)));
  assert_scan_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sel == LAST) |=> !active);
endmodule

// File: tb/raster_mark_scan_test.sv
`timescale 1ns/100ps
module raster_mark_scan_test;
  localparam int AW = 9;
  logic clk = 0, rst_n = 0, retrace = 0, data_loaded = 0, erase_req = 0;
  logic [AW-1:0] move_addr = 0, line_cnt = 0;
  logic [6*AW-1:0] stored_addr = 0;
  logic [5:0] stored_busy = 0;
  logic eq_pulse, draw_pulse, erase_pulse, load_pulse;
  logic [2:0] eq_src;
  logic [AW-1:0] load_line;

  int total = 0, bad = 0;
  bit done = 0;
  logic [AW-1:0] lc_model = 0;
  logic [5:0] q[$];

  always #2.5 clk = ~clk;

  raster_mark_scan #(.AW(AW)) uut (.*);

  function automatic logic [AW-1:0] slot(input int i);
    return stored_addr[i*AW +: AW];
  endfunction

  task automatic set_slot(input int i, input logic [AW-1:0] a, input bit busy);
    stored_addr[i*AW +: AW] = a;
    stored_busy[i] = busy;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: computes expected items (R2..R7) and runs one scan.
  task automatic run_scan(input logic [AW-1:0] line, input bit redo);
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      bit v, er;
      v = 1; er = 0;
      if (k == 0) a = move_addr;
      else if (k == 7) a = lc_model;
      else begin
        a = slot(k - 1);
        v = stored_busy[k-1];
        er = erase_req && (a == move_addr);
      end
      if (v && a == line) q.push_back({3'(k), k != 7, er, k == 7});
    end
    @(negedge clk); line_cnt = line; retrace = 1;
    @(negedge clk); line_cnt = line + 9'd3;
    if (redo) begin
      retrace = 0; @(negedge clk); @(negedge clk); retrace = 1; @(negedge clk);
    end
    retrace = 0;
    repeat (14) @(negedge clk);
    check(q.size() == 0, "R3 pending pulses at scan end", q.size(), 0);
    q.delete();
  endtask

  task automatic data_load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_loaded = 1; lc_model = lc_model + 1'b1;
    end
    @(negedge clk); data_loaded = 0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) if (rst_n && !done) begin
    if (eq_pulse) begin
      if (q.size() == 0) check(0, "R3 unexpected pulse src", eq_src, -1);
      else begin
        logic [5:0] e, g;
        e = q.pop_front();
        g = {eq_src, draw_pulse, erase_pulse, load_pulse};
        check(g == e, "R3/R4/R5/R7 item {src,draw,erase,load}", g, e);
      end
    end else if (draw_pulse || erase_pulse || load_pulse)
      check(0, "R4/R5/R7 action without match", {draw_pulse, erase_pulse, load_pulse}, 0);
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({eq_pulse, draw_pulse, erase_pulse, load_pulse} == 0, "R1 pulses in reset", eq_pulse, 0);
    check(load_line == 0, "R1 counter in reset", load_line, 0);
    rst_n = 1;
    @(negedge clk);
    check({eq_pulse, draw_pulse, erase_pulse, load_pulse} == 0, "R1 pulses after reset", eq_pulse, 0);
    check(load_line == 0, "R1 counter after reset", load_line, 0);

    // R2/R4: only moving cursor on the line; capture ignores later line_cnt
    move_addr = 100;
    for (int i = 0; i < 6; i++) set_slot(i, 9'(200 + i), 1);
    run_scan(100, 0);
    // R2: line moved to a slot value after start must not match it
    run_scan(200 - 3, 0);

    // R3/R5: moving, slots 2,5 and load line all on line 5
    data_load(5);
    check(load_line == 5, "R8 count after 5 strobes", load_line, 5);
    move_addr = 5; set_slot(1, 5, 1); set_slot(4, 5, 1);
    run_scan(5, 0);

    // R6: slots hold the line but are idle
    move_addr = 50; set_slot(1, 60, 0); set_slot(4, 60, 0); set_slot(2, 60, 1);
    run_scan(60, 0);

    // R7: erase when slot sits on the moving cursor
    erase_req = 1; move_addr = 70; set_slot(0, 70, 1); set_slot(3, 70, 1); set_slot(5, 71, 1);
    run_scan(70, 0);
    // R7: slot hits line but moving cursor elsewhere: no erase
    run_scan(71, 0);
    erase_req = 0;

    // R3: no match at all
    run_scan(400, 0);

    // R9: second retrace rise during scan ignored
    move_addr = 300; set_slot(2, 300, 1);
    run_scan(300, 1);

    // R8: wrap 511 -> 0
    data_load(506);
    check(load_line == 511, "R8 count at 511", load_line, 511);
    data_load(1);
    check(load_line == 0, "R8 wrap to 0", load_line, 0);
    move_addr = 1; run_scan(0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule